// File: doc/BRIEF.md
# Multi-Scheme Page Table Walker

This block converts a virtual address into a physical address by walking a radix page table in memory, one level per memory read, for any of three translation schemes (Sv32, Sv39, Sv48). Before any walk it works out the effective privilege of the access and decides whether translation applies at all. When translation is bypassed, the address comes back masked to the active register width.

A request is accepted while the walker is idle. The walker then reads page-table entries through a single valid/ready memory port. It descends through pointer entries and checks the leaf against the access kind and privilege. On success it writes the leaf back with its referenced bit set, and also its dirty bit for stores, then reports the physical page with the page offset. Superpage leaves fill the low page-number bits from the virtual address. Any failure ends in a one-cycle fault pulse.

Top module: `ptw_top`

## Requirements
- R1: The effective privilege is `statMpp` when `statMprv` is 1 and the access is not a fetch; otherwise it is `privCur`. Kind encoding: 0 fetch, 1 load, 2 store. Privilege encoding: 0 user, 1 supervisor, 3 machine.
- R2: When `vmMode` is 0 (bare) or the effective privilege is machine, no memory access is made. `doneValid` pulses with `donePaddr` equal to the virtual address, masked to its low 32 bits when `xlenIs32` is 1. This takes precedence over the canonical check.
- R3: The check covers address bits from xlen-1 down to vaBits-1, where vaBits is 12 plus levels times index width. If those bits are neither all zeros nor all ones, the request faults without any memory access.
- R4: `vmMode` 1 selects Sv32: 2 levels, 10-bit indices, 4-byte entries. `vmMode` 2 selects Sv39: 3 levels, 9-bit indices, 8-byte entries. `vmMode` 3 selects Sv48: 4 levels, 9-bit indices, 8-byte entries. The first entry address is `rootPpn`<<12 plus the top index times the entry size, and lower slices follow level by level. A 4-byte entry travels in bits 31:0 of the data buses with `memWide` low.
- R5: An entry with V (bit 0) set and R, W, X (bits 1, 2, 3) all clear is a pointer. The next base is its PPN (bits from 10 up) shifted left by 12. A pointer at the last level faults.
- R6: An entry address outside [MEM_BASE, MEM_BASE+MEM_SIZE) faults, and that read is not issued.
- R7: A leaf must have V set. It must have R for loads, W for stores and X for fetches. At user privilege it must also have U (bit 4). Otherwise the request faults.
- R8: At effective supervisor privilege with `statPum` set, a leaf that would grant the access at user level (U set) faults.
- R9: A successful leaf is written back before `doneValid`, with A (bit 6) set and, for stores only, D (bit 7) set. A faulting request leaves the entry unchanged.
- R10: The physical page of a leaf found with k levels still below it is the leaf PPN ORed with the low k times index-width bits of the virtual page number. The 12-bit page offset passes through.
- R11: `memValid` stays high with a stable address and write flag until `memReady`. Exactly one read is made per level visited, plus one write for a successful leaf.
- R12: Each accepted request ends in exactly one one-cycle pulse, either `doneValid` or `faultValid`. `busy` is low after reset and high from acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start a translation (taken when not busy) |
| reqVaddr | input | 64 | Virtual address |
| reqKind | input | 2 | 0 fetch, 1 load, 2 store |
| privCur | input | 2 | Current privilege |
| statMprv | input | 1 | Data accesses use the saved privilege |
| statMpp | input | 2 | Saved privilege |
| statPum | input | 1 | Supervisor may not touch user pages |
| vmMode | input | 2 | 0 bare, 1 Sv32, 2 Sv39, 3 Sv48 |
| xlenIs32 | input | 1 | Register width is 32 bits |
| rootPpn | input | 64 | Root table page number |
| busy | output | 1 | Request in progress |
| memValid | output | 1 | Memory access request |
| memWrite | output | 1 | Access is an entry write-back |
| memWide | output | 1 | 8-byte entry (else 4-byte) |
| memAddr | output | 64 | Entry byte address |
| memWdata | output | 64 | Write-back data |
| memReady | input | 1 | Memory accepts; read data valid this cycle |
| memRdata | input | 64 | Read data |
| doneValid | output | 1 | Translation succeeded |
| donePaddr | output | 64 | Physical address, valid with doneValid |
| faultValid | output | 1 | Translation failed |

## Verification
The assertions assume that the memory answers every request eventually. They also assume the privilege, mode and root inputs are only read at acceptance. The bench changes these inputs only while the walker is idle, and its memory model answers after a programmable delay. The stimulus pairs Sv32 only with a 32-bit register width and keeps every table inside the legal window, except for the cases that deliberately test the window. The sweeps cover each scheme, leaf level and kind. They also cover each combination of privilege, PUM, U flag and single permission bit, with the expected address and fault outcome computed arithmetically.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {KIND_FETCH = 2'd0, KIND_LOAD = 2'd1, KIND_STORE = 2'd2} kind_e;
  typedef enum logic [1:0] {VM_BARE = 2'd0, VM_SV32 = 2'd1, VM_SV39 = 2'd2, VM_SV48 = 2'd3} vm_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W = 2;
  localparam int PTE_X = 3;
  localparam int PTE_U = 4;
  localparam int PTE_A = 6;
  localparam int PTE_D = 7;

  typedef struct packed {
    logic accept;
    logic capturePte;
    logic descend;
  } ctrl_strobe_t;

  typedef struct packed {
    logic bypass;
    logic canonOk;
    logic pteLegal;
    logic isPointer;
    logic lastLevel;
    logic permOk;
  } dp_status_t;
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int PPN_SHIFT = 10,
  parameter logic [XLEN-1:0] MEM_BASE = 64'h0000_0000_8000_0000,
  parameter logic [XLEN-1:0] MEM_SIZE = 64'h0000_0000_1000_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_strobe_t    strobe,
  input  logic [XLEN-1:0] reqVaddr,
  input  logic [1:0]      reqKind,
  input  logic [1:0]      privCur,
  input  logic            statMprv,
  input  logic [1:0]      statMpp,
  input  logic            statPum,
  input  logic [1:0]      vmMode,
  input  logic            xlenIs32,
  input  logic [XLEN-1:0] rootPpn,
  input  logic [63:0]     memRdata,
  output dp_status_t      status,
  output logic [XLEN-1:0] memAddr,
  output logic [63:0]     memWdata,
  output logic            memWide,
  output logic [XLEN-1:0] outPaddr
);
  localparam logic [XLEN-1:0] ONE_X = XLEN'(1);
  localparam logic [XLEN-1:0] LOW32 = {{(XLEN-32){1'b0}}, 32'hFFFF_FFFF};
  localparam logic [XLEN-1:0] OFFSET_MASK = (ONE_X << PAGE_SHIFT) - ONE_X;

  logic [XLEN-1:0] vaR, baseR;
  logic [1:0]      kindR, vmR, levelR;
  logic            narrowR, bypassR, userLvlR, pumR;
  logic [63:0]     pteR;

  logic [1:0] effMode;
  logic       bypassIn;

  int numLevels, idxBits, pteBytes;
  int vaBits, hiWidth, xlenBits, ptShift;
  logic [XLEN-1:0] hiBits, hiMask, idx, lowMask, vpn, leafPage, ppn, pteAddr;
  logic [63:0] pteWord;
  logic canonOk, pteLegal, isPointer, lastLevel, permOk;

  // Effective privilege and bypass decision, evaluated at acceptance
  always_comb begin
    effMode  = (reqKind != KIND_FETCH && statMprv) ? statMpp : privCur;
    bypassIn = (vmMode == VM_BARE) || (effMode == PRIV_M);
  end

  // Scheme geometry
  always_comb begin
    unique case (vm_e'(vmR))
      VM_SV32: begin numLevels = 2; idxBits = 10; pteBytes = 4; end
      VM_SV48: begin numLevels = 4; idxBits = 9;  pteBytes = 8; end
      default: begin numLevels = 3; idxBits = 9;  pteBytes = 8; end
    endcase
  end

  function automatic logic grants(input logic [63:0] p, input logic [1:0] k, input logic asUser);
    logic need;
    case (kind_e'(k))
      KIND_FETCH: need = p[PTE_X];
      KIND_STORE: need = p[PTE_W];
      default:    need = p[PTE_R];
    endcase
    return p[PTE_V] && need && (!asUser || p[PTE_U]);
  endfunction

  always_comb begin
    xlenBits = narrowR ? 32 : XLEN;
    vaBits   = PAGE_SHIFT + numLevels * idxBits;
    hiWidth  = xlenBits - (vaBits - 1);
    hiBits   = vaR >> (vaBits - 1);
    hiMask   = (hiWidth >= XLEN) ? '1 : ((ONE_X << hiWidth) - ONE_X);
    canonOk  = ((hiBits & hiMask) == '0) || ((hiBits & hiMask) == hiMask);

    ptShift  = (numLevels - 1 - int'(levelR)) * idxBits;
    idx      = (vaR >> (PAGE_SHIFT + ptShift)) & ((ONE_X << idxBits) - ONE_X);
    pteAddr  = baseR + idx * XLEN'(pteBytes);
    pteLegal = (pteAddr >= MEM_BASE) && ((pteAddr - MEM_BASE) < MEM_SIZE);

    pteWord   = (vmR == VM_SV32) ? {32'd0, pteR[31:0]} : pteR;
    ppn       = XLEN'(pteWord >> PPN_SHIFT);
    isPointer = pteWord[PTE_V] && !pteWord[PTE_R] && !pteWord[PTE_W] && !pteWord[PTE_X];
    lastLevel = (int'(levelR) == numLevels - 1);
    permOk    = pumR ? (grants(pteWord, kindR, 1'b0) && !grants(pteWord, kindR, 1'b1))
                     : grants(pteWord, kindR, userLvlR);

    lowMask  = (ONE_X << ptShift) - ONE_X;
    vpn      = vaR >> PAGE_SHIFT;
    leafPage = ppn | (vpn & lowMask);
  end

  always_comb begin
    status.bypass    = bypassR;
    status.canonOk   = canonOk;
    status.pteLegal  = pteLegal;
    status.isPointer = isPointer;
    status.lastLevel = lastLevel;
    status.permOk    = permOk;
    memAddr  = pteAddr;
    memWide  = (vmR != VM_SV32);
    memWdata = pteWord | (64'd1 << PTE_A) | ((kindR == KIND_STORE) ? (64'd1 << PTE_D) : 64'd0);
    outPaddr = bypassR ? (vaR & (narrowR ? LOW32 : '1))
                       : ((leafPage << PAGE_SHIFT) | (vaR & OFFSET_MASK));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaR      <= '0;
      baseR    <= '0;
      kindR    <= '0;
      vmR      <= '0;
      levelR   <= '0;
      narrowR  <= 1'b0;
      bypassR  <= 1'b0;
      userLvlR <= 1'b0;
      pumR     <= 1'b0;
      pteR     <= '0;
    end else begin
      if (strobe.accept) begin
        vaR      <= reqVaddr;
        kindR    <= reqKind;
        vmR      <= vmMode;
        narrowR  <= xlenIs32;
        bypassR  <= bypassIn;
        userLvlR <= (effMode == PRIV_U);
        pumR     <= (effMode == PRIV_S) && statPum;
        baseR    <= rootPpn << PAGE_SHIFT;
        levelR   <= '0;
      end
      if (strobe.capturePte) pteR <= memRdata;
      if (strobe.descend) begin
        baseR  <= ppn << PAGE_SHIFT;
        levelR <= levelR + 2'd1;
      end
    end
  end

  // Descending only happens from a level that is not the last one
  assert_descend_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.descend |-> !lastLevel);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  dp_status_t   status,
  input  logic         memReady,
  output ctrl_strobe_t strobe,
  output logic         memValid,
  output logic         memWrite,
  output logic         busy,
  output logic         doneValid,
  output logic         faultValid
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_EVAL, ST_WRITEBACK, ST_DONE, ST_FAULT
  } state_e;

  state_e state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.accept = 1'b1;
        nextState     = ST_CHECK;
      end
      ST_CHECK: begin
        if (status.bypass)        nextState = ST_DONE;
        else if (!status.canonOk) nextState = ST_FAULT;
        else                      nextState = ST_READ;
      end
      ST_READ: begin
        if (!status.pteLegal) nextState = ST_FAULT;
        else begin
          memValid = 1'b1;
          if (memReady) begin
            strobe.capturePte = 1'b1;
            nextState         = ST_EVAL;
          end
        end
      end
      ST_EVAL: begin
        if (status.isPointer) begin
          if (status.lastLevel) nextState = ST_FAULT;
          else begin
            strobe.descend = 1'b1;
            nextState      = ST_READ;
          end
        end else if (status.permOk) nextState = ST_WRITEBACK;
        else                        nextState = ST_FAULT;
      end
      ST_WRITEBACK: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        if (memReady) nextState = ST_DONE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy       = (state != ST_IDLE);
  assign doneValid  = (state == ST_DONE);
  assign faultValid = (state == ST_FAULT);

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memWrite));

  assert_bypass_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK) && status.bypass |=> doneValid && !memValid);

  assert_canon_fault_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK) && !status.bypass && !status.canonOk |=> faultValid);

  assert_single_outcome_R12: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid || faultValid) |=> !busy);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int PPN_SHIFT = 10,
  parameter logic [XLEN-1:0] MEM_BASE = 64'h0000_0000_8000_0000,
  parameter logic [XLEN-1:0] MEM_SIZE = 64'h0000_0000_1000_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [XLEN-1:0] reqVaddr,
  input  logic [1:0]      reqKind,
  input  logic [1:0]      privCur,
  input  logic            statMprv,
  input  logic [1:0]      statMpp,
  input  logic            statPum,
  input  logic [1:0]      vmMode,
  input  logic            xlenIs32,
  input  logic [XLEN-1:0] rootPpn,
  output logic            busy,
  output logic            memValid,
  output logic            memWrite,
  output logic            memWide,
  output logic [XLEN-1:0] memAddr,
  output logic [63:0]     memWdata,
  input  logic            memReady,
  input  logic [63:0]     memRdata,
  output logic            doneValid,
  output logic [XLEN-1:0] donePaddr,
  output logic            faultValid
);
  ctrl_strobe_t strobe;
  dp_status_t   status;

  ptw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .status(status), .memReady(memReady),
    .strobe(strobe), .memValid(memValid), .memWrite(memWrite), .busy(busy),
    .doneValid(doneValid), .faultValid(faultValid)
  );

  ptw_datapath #(
    .XLEN(XLEN), .PAGE_SHIFT(PAGE_SHIFT), .PPN_SHIFT(PPN_SHIFT),
    .MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr), .reqKind(reqKind),
    .privCur(privCur), .statMprv(statMprv), .statMpp(statMpp), .statPum(statPum),
    .vmMode(vmMode), .xlenIs32(xlenIs32), .rootPpn(rootPpn), .memRdata(memRdata),
    .status(status), .memAddr(memAddr), .memWdata(memWdata), .memWide(memWide),
    .outPaddr(donePaddr)
  );

  assert_read_in_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memWrite |-> (memAddr >= MEM_BASE) && ((memAddr - MEM_BASE) < MEM_SIZE));

  assert_wb_sets_ref_R9: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memWrite |-> memWdata[PTE_A]);

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> $stable(memAddr));
endmodule

// File: tb/test_ptw_top.sv
module test_ptw_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ROOT = 64'h80010;
  localparam logic [63:0] PPN64 = 64'h9000_0000;
  localparam logic [63:0] PPN32 = 64'h30_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [63:0] reqVaddr = '0;
  logic [1:0] reqKind = '0, privCur = '0, statMpp = '0, vmMode = '0;
  logic statMprv = 1'b0, statPum = 1'b0, xlenIs32 = 1'b0;
  logic [63:0] rootPpn = ROOT;
  logic busy, memValid, memWrite, memWide, doneValid, faultValid;
  logic [63:0] memAddr, memWdata, donePaddr;
  logic memReady = 1'b0;
  logic [63:0] memRdata = '0;

  logic [63:0] memArr [logic [63:0]];
  logic [63:0] word;
  int memDelay = 0, memWait = 0, memOps = 0, memWrites = 0, outcomes = 0;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_top i_ptw_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr), .reqKind(reqKind),
    .privCur(privCur), .statMprv(statMprv), .statMpp(statMpp), .statPum(statPum),
    .vmMode(vmMode), .xlenIs32(xlenIs32), .rootPpn(rootPpn), .busy(busy),
    .memValid(memValid), .memWrite(memWrite), .memWide(memWide), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata),
    .doneValid(doneValid), .donePaddr(donePaddr), .faultValid(faultValid)
  );

  // Memory model: answers after memDelay idle cycles
  always @(negedge clk) begin
    if (memValid && !memReady) begin
      if (memWait < memDelay) memWait++;
      else begin
        memWait = 0;
        memReady = 1'b1;
        memOps++;
        word = memArr.exists(memAddr >> 3) ? memArr[memAddr >> 3] : 64'd0;
        if (memWrite) begin
          memWrites++;
          if (memWide) memArr[memAddr >> 3] = memWdata;
          else memArr[memAddr >> 3] = memAddr[2] ? {memWdata[31:0], word[31:0]}
                                                 : {word[63:32], memWdata[31:0]};
        end else begin
          memRdata = memWide ? word : (memAddr[2] ? {32'd0, word[63:32]} : {32'd0, word[31:0]});
        end
      end
    end else memReady = 1'b0;
    if (doneValid || faultValid) outcomes++;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      summary();
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void geo(input int vm, output int n, output int b, output int sz);
    if (vm == 1) begin n = 2; b = 10; sz = 4; end
    else if (vm == 3) begin n = 4; b = 9; sz = 8; end
    else begin n = 3; b = 9; sz = 8; end
  endfunction

  function automatic void pteWrite(input logic [63:0] a, input logic [63:0] v, input logic wide);
    logic [63:0] w;
    w = memArr.exists(a >> 3) ? memArr[a >> 3] : 64'd0;
    if (wide) memArr[a >> 3] = v;
    else memArr[a >> 3] = a[2] ? {v[31:0], w[31:0]} : {w[63:32], v[31:0]};
  endfunction

  function automatic logic [63:0] pteRead(input logic [63:0] a, input logic wide);
    logic [63:0] w;
    w = memArr.exists(a >> 3) ? memArr[a >> 3] : 64'd0;
    return wide ? w : (a[2] ? {32'd0, w[63:32]} : {32'd0, w[31:0]});
  endfunction

  function automatic logic [63:0] entryAddr(input int vm, input logic [63:0] va, input int lvl);
    int n, b, sz;
    logic [63:0] ix;
    geo(vm, n, b, sz);
    ix = (va >> (12 + (n - 1 - lvl) * b)) & ((64'd1 << b) - 1);
    return ((ROOT + 64'(lvl)) << 12) + ix * 64'(sz);
  endfunction

  // Pointer chain from the root down to leafLvl, then the given leaf entry
  function automatic void buildWalk(input int vm, input logic [63:0] va, input int leafLvl, input logic [63:0] leafPte);
    memArr.delete();
    for (int i = 0; i <= leafLvl; i++)
      pteWrite(entryAddr(vm, va, i),
               (i == leafLvl) ? leafPte : (((ROOT + 64'(i) + 1) << 10) | 64'h1), vm != 1);
  endfunction

  function automatic logic [63:0] expPa(input int vm, input logic [63:0] va, input int lvl, input logic [63:0] ppn);
    int n, b, sz, sh;
    geo(vm, n, b, sz);
    sh = (n - 1 - lvl) * b;
    return ((ppn | ((va >> 12) & ((64'd1 << sh) - 1))) << 12) | (va & 64'hFFF);
  endfunction

  logic gotDone, gotFault;
  logic [63:0] gotPa;
  int opsBefore, outBefore;

  task automatic runReq(input logic [63:0] va, input logic [1:0] kind);
    opsBefore = memOps;
    outBefore = outcomes;
    @(negedge clk);
    reqVaddr = va;
    reqKind  = kind;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    gotDone = 1'b0;
    gotFault = 1'b0;
    gotPa = '0;
    for (int k = 0; k < 80; k++) begin
      if (doneValid || faultValid) begin
        gotDone = doneValid;
        gotFault = faultValid;
        gotPa = donePaddr;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic setPriv(input logic [1:0] cur, input logic mprv, input logic [1:0] mpp, input logic pum);
    privCur = cur; statMprv = mprv; statMpp = mpp; statPum = pum;
  endtask

  initial begin
    logic [63:0] va, ppn, ent;
    int n, b, sz;
    repeat (3) @(negedge clk);
    // reset state
    chk("R12", "busy after reset", 64'(busy), 64'd0);
    chk("R12", "done after reset", 64'(doneValid), 64'd0);
    chk("R12", "fault after reset", 64'(faultValid), 64'd0);
    chk("R11", "memValid after reset", 64'(memValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: bare mode, both widths
    vmMode = 2'd0; setPriv(2'd1, 1'b0, 2'd0, 1'b0); xlenIs32 = 1'b0;
    runReq(64'hFFFF_0000_1234_5678, 2'd1);
    chk("R2", "bare done", 64'(gotDone), 64'd1);
    chk("R2", "bare paddr", gotPa, 64'hFFFF_0000_1234_5678);
    chk("R2", "bare no memory", 64'(memOps - opsBefore), 64'd0);
    xlenIs32 = 1'b1;
    runReq(64'hFFFF_0000_1234_5678, 2'd2);
    chk("R2", "bare 32-bit paddr", gotPa, 64'h0000_0000_1234_5678);
    xlenIs32 = 1'b0;
    // R2: machine mode skips the canonical check
    vmMode = 2'd2; setPriv(2'd3, 1'b0, 2'd0, 1'b0);
    runReq(64'h0000_0080_0000_0000, 2'd0);
    chk("R2", "machine bypass done", 64'(gotDone), 64'd1);
    chk("R2", "machine bypass paddr", gotPa, 64'h0000_0080_0000_0000);

    // R1: MPRV redirects data accesses but not fetches
    va = 64'h0000_0012_3456_7ABC;
    buildWalk(2, va, 2, (PPN64 << 10) | 64'h1F);
    setPriv(2'd3, 1'b1, 2'd1, 1'b0);
    runReq(va, 2'd1);
    chk("R1", "mprv load walks", gotPa, expPa(2, va, 2, PPN64));
    runReq(va, 2'd0);
    chk("R1", "mprv fetch bypassed", gotPa, va);
    setPriv(2'd3, 1'b1, 2'd3, 1'b0);
    runReq(va, 2'd2);
    chk("R1", "mprv to machine bypassed", gotPa, va);
    setPriv(2'd1, 1'b1, 2'd0, 1'b0);
    buildWalk(2, va, 2, (PPN64 << 10) | 64'h0F);
    runReq(va, 2'd1);
    chk("R1", "mprv to user on non-user page faults", 64'(gotFault), 64'd1);

    // R4, R9, R10, R11, R12: every scheme, leaf level and kind
    for (int vm = 1; vm <= 3; vm++) begin
      geo(vm, n, b, sz);
      vmMode = 2'(vm);
      xlenIs32 = (vm == 1);
      va = (vm == 1) ? 64'h0000_0000_C123_4567 :
           (vm == 2) ? 64'hFFFF_FFC0_1234_5678 : 64'h0000_7A12_3456_789A;
      ppn = (vm == 1) ? PPN32 : PPN64;
      for (int lvl = 0; lvl < n; lvl++) begin
        for (int kind = 0; kind < 3; kind++) begin
          setPriv(2'd0, 1'b0, 2'd0, 1'b0);
          memDelay = (lvl + kind) % 3;
          buildWalk(vm, va, lvl, (ppn << 10) | 64'h1F);
          runReq(va, 2'(kind));
          chk("R4", "walk done", 64'(gotDone), 64'd1);
          chk("R10", "walk paddr", gotPa, expPa(vm, va, lvl, ppn));
          chk("R11", "reads plus write", 64'(memOps - opsBefore), 64'(lvl + 2));
          chk("R12", "one outcome", 64'(outcomes - outBefore), 64'd1);
          ent = pteRead(entryAddr(vm, va, lvl), vm != 1);
          chk("R9", "ref and dirty bits", (ent >> 6) & 64'h3, (kind == 2) ? 64'h3 : 64'h1);
        end
      end
    end
    memDelay = 0;
    xlenIs32 = 1'b0;

    // R3: non-canonical addresses
    vmMode = 2'd2; setPriv(2'd1, 1'b0, 2'd0, 1'b0);
    runReq(64'h0000_0080_0000_0000, 2'd1);
    chk("R3", "sv39 non-canonical fault", 64'(gotFault), 64'd1);
    chk("R3", "sv39 no memory", 64'(memOps - opsBefore), 64'd0);
    vmMode = 2'd3;
    runReq(64'h0001_0000_0000_0000, 2'd1);
    chk("R3", "sv48 non-canonical fault", 64'(gotFault), 64'd1);

    // R5: pointer at the last level
    va = 64'h0000_0012_3456_7ABC;
    vmMode = 2'd2;
    buildWalk(2, va, 2, (PPN64 << 10) | 64'h1);
    runReq(va, 2'd1);
    chk("R5", "pointer at last level faults", 64'(gotFault), 64'd1);
    chk("R5", "reads before fault", 64'(memOps - opsBefore), 64'd3);

    // R6: illegal entry addresses
    rootPpn = 64'h10;
    runReq(va, 2'd1);
    chk("R6", "root outside window faults", 64'(gotFault), 64'd1);
    chk("R6", "no read issued", 64'(memOps - opsBefore), 64'd0);
    rootPpn = ROOT;
    memArr.delete();
    pteWrite(entryAddr(2, va, 0), (64'h20 << 10) | 64'h1, 1'b1);
    runReq(va, 2'd1);
    chk("R6", "pointer outside window faults", 64'(gotFault), 64'd1);
    chk("R6", "only root read", 64'(memOps - opsBefore), 64'd1);

    // R7, R8: privilege x PUM x U flag x kind x single permission bit
    for (int priv = 0; priv < 2; priv++)
      for (int pum = 0; pum < 2; pum++)
        for (int u = 0; u < 2; u++)
          for (int kind = 0; kind < 3; kind++)
            for (int perm = 1; perm <= 3; perm++) begin
              logic expOk, needOk;
              setPriv(2'(priv), 1'b0, 2'd0, 1'(pum));
              buildWalk(2, va, 2, (PPN64 << 10) | 64'h1 | (64'(u) << 4) | (64'd1 << perm));
              runReq(va, 2'(kind));
              needOk = (kind == 0) ? (perm == 3) : (kind == 2) ? (perm == 2) : (perm == 1);
              expOk = needOk && ((priv == 0) ? (u == 1) : !(pum == 1 && u == 1));
              chk((priv == 1 && pum == 1) ? "R8" : "R7", "leaf outcome", 64'(gotDone), 64'(expOk));
              if (!expOk) begin
                ent = pteRead(entryAddr(2, va, 2), 1'b1);
                chk("R9", "faulting entry unchanged", (ent >> 6) & 64'h3, 64'd0);
              end
            end

    // R7: invalid leaf
    setPriv(2'd1, 1'b0, 2'd0, 1'b0);
    buildWalk(2, va, 2, (PPN64 << 10) | 64'h0E);
    runReq(va, 2'd1);
    chk("R7", "invalid leaf faults", 64'(gotFault), 64'd1);

    summary();
  end
endmodule